// File: doc/BRIEF.md
# CAN Message RAM Power Sequencer

This block is the global control point of a multi-channel CAN subsystem. Each channel has one clock-stop request bit, which software writes through a 32-bit register port and which drives that channel's stop request output. The block also holds a power switch for the message RAM that all channels share. Software may power the RAM down only once every channel has acknowledged its clock stop. A write that tries it earlier is refused and recorded in a sticky error flag.

When the RAM is powered back up, a settle counter loads a 16-bit delay value and counts down once per clock. The RAM is reported ready only when the counter reaches zero. During that window, any write that clears a stop request is held off at the output until the RAM is ready. Any RAM access made while the RAM is unpowered or still settling is reported as an address error. The error is a one-cycle pulse for each offending access, as if the RAM had no storage at all. The RAM-off bit has to be returned to 0 before the device enters hibernate. Enforcing that rule is left to software.

Top module: `canram_pwr_seq`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 0x0000_0000, every stop request output is low, the RAM power enable is high, the RAM is ready, and the status word reads 0x0000_0005.
- R2: A write to the control word (address 0) stores bits 7:0 as the per-channel stop requests. Bit n drives stop request output n from the clock after the write. The stored bits read back in bits 7:0.
- R3: Bits 30:8 of the control word always read as zero, and writing ones to them changes nothing.
- R4: Writing bit 31 of the control word as 1 while every stop acknowledge input is high switches the RAM off. The power enable goes low and ready goes low from the clock after the write, and bit 31 reads back 1.
- R5: A write that would change bit 31 from 0 to 1 while any stop acknowledge is low is discarded in full. The control word keeps its prior value, and the sticky sequence-error flag (status bit 1) is set. Writing status (address 1) with bit 1 set clears that flag.
- R6: A write that clears bit 31 while the RAM is off raises the power enable and loads the settle counter from the delay input. With delay D, ready rises exactly D clocks after the first clock following the write, or on that clock when D is 0.
- R7: While the settle counter is nonzero, a stop request bit cleared by a write stays asserted at its output. It falls on the same clock on which ready rises. This also applies when the write that powers the RAM up clears stop bits itself.
- R8: A RAM access presented while the RAM is off or settling produces an address error pulse on the following clock, one cycle long per access. An access while ready produces none.
- R9: The status word (address 1) reports ready in bit 0, the sequence-error flag in bit 1 and the power enable in bit 2, with all other bits zero. The read port is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects control word, 1 selects status word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed word |
| stop_ack_i | input | 8 | Per-channel clock-stop acknowledge |
| stop_req_o | output | 8 | Per-channel clock-stop request |
| settle_dly_i | input | 16 | Power-up settle delay in clocks |
| ram_pwr_en_o | output | 1 | Message RAM power enable |
| ram_ready_o | output | 1 | RAM powered and settled |
| ram_acc_i | input | 1 | A RAM access is presented this cycle |
| ram_addr_err_o | output | 1 | Address error pulse for a refused access |

## Verification
Register reads are combinational, so they are compared in the same cycle as the address. Stop requests, power enable and ready change on the first clock after a write. The address error follows its access by exactly one clock, and ready follows a power-up write by D further clocks. The bench keeps a cycle-accurate reference model that is updated at each rising edge from the inputs held across it. It compares every output half a period later, at the falling edge, before the next inputs are driven. Directed sequences cover delays of 0 and 3 and a refused power-down. A seeded random phase then mixes power cycles, acknowledge gaps and accesses.

// File: rtl/canram_pkg.sv
// Package: shared constants for the message RAM power sequencer.
// Assumes a single-bit register address and a 32-bit data word.
package canram_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned OFF_BIT  = 31;
    localparam logic        ADDR_CTL = 1'b0;
    localparam logic        ADDR_STS = 1'b1;
    localparam int unsigned STS_RDY  = 0;
    localparam int unsigned STS_SEQ  = 1;
    localparam int unsigned STS_PWR  = 2;
endpackage

// File: rtl/canram_settle.sv
// Module: power-up settle counter.
// Loads the delay on a power-up event, then counts down to zero.
// Ready is high when the RAM is powered and the count is zero.
// Assumes pwr_up_i pulses for one clock on the write that powers the RAM up.
module canram_settle #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_up_i,
    input  logic             ram_off_i,
    input  logic [CNT_W-1:0] dly_i,
    output logic             settling_o,
    output logic             ready_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             past_valid;

    // Counter: load on wake, clear while off, else count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (pwr_up_i) begin
            cnt_q <= dly_i;
        end else if (ram_off_i) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Status decode from the counter and the power state.
    always_comb begin
        settling_o = !ram_off_i && (cnt_q != '0);
        ready_o    = !ram_off_i && (cnt_q == '0);
    end

    // History flag so $past is only read after a reset cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    assert_load_on_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(pwr_up_i)) |-> (cnt_q == $past(dly_i)));

    assert_countdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(settling_o) && !$past(pwr_up_i) && !ram_off_i)
            |-> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/canram_guard.sv
// Module: RAM access guard.
// Flags each access seen while the RAM is not ready with a one-clock
// registered address error pulse.
module canram_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_i,
    input  logic ready_i,
    output logic err_o
);
    logic past_valid;

    // Register one error pulse per refused access.
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= acc_i && !ready_i;
    end

    // History flag so $past is only read after a reset cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && err_o) |-> $past(acc_i && !ready_i));

    assert_no_err_when_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(ready_i)) |-> !err_o);
endmodule

// File: rtl/canram_regs.sv
// Module: control and status register file.
// Holds the per-channel stop requests, the RAM-off bit and the sticky
// sequence-error flag. Refuses a power-down while any acknowledge is low.
// Holds cleared stop requests at the outputs during the settle window.
// Assumes NCH <= 8 so the stop bits fit below the reserved field.
module canram_regs
    import canram_pkg::*;
#(
    parameter int unsigned NCH   = 8,
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [NCH-1:0]    stop_ack_i,
    input  logic [CNT_W-1:0]  dly_i,
    input  logic              settling_i,
    input  logic              ready_i,
    output logic [NCH-1:0]    stop_req_o,
    output logic              ram_off_o,
    output logic              pwr_up_o
);
    logic [NCH-1:0] stop_q;
    logic [NCH-1:0] hold_q;
    logic           off_q;
    logic           seq_q;
    logic           wr_ctl;
    logic           wr_sts;
    logic           bad_off;
    logic           accept;
    logic           hold_arm;
    logic           past_valid;
    logic           unused_wbits;

    // Write decode and power-down legality check.
    always_comb begin
        wr_ctl   = wr_en_i && (addr_i == ADDR_CTL);
        wr_sts   = wr_en_i && (addr_i == ADDR_STS);
        bad_off  = wr_ctl && wdata_i[OFF_BIT] && !off_q && !(&stop_ack_i);
        accept   = wr_ctl && !bad_off;
        pwr_up_o = accept && off_q && !wdata_i[OFF_BIT];
        hold_arm = accept && (settling_i || (pwr_up_o && (dly_i != '0)));
    end

    // Control word and sticky flag state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= '0;
            off_q  <= 1'b0;
            seq_q  <= 1'b0;
        end else begin
            if (accept) begin
                stop_q <= wdata_i[NCH-1:0];
                off_q  <= wdata_i[OFF_BIT];
            end
            if (bad_off) begin
                seq_q <= 1'b1;
            end else if (wr_sts && wdata_i[STS_SEQ]) begin
                seq_q <= 1'b0;
            end
        end
    end

    // Per-channel hold-off of cleared requests during the settle window.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q[ch] <= 1'b0;
            end else if (hold_arm) begin
                if (stop_q[ch] && !wdata_i[ch]) hold_q[ch] <= 1'b1;
            end else if (!settling_i) begin
                hold_q[ch] <= 1'b0;
            end
        end
        assign stop_req_o[ch] = stop_q[ch] || (hold_q[ch] && settling_i);
    end

    assign ram_off_o    = off_q;
    assign unused_wbits = ^wdata_i[OFF_BIT-1:NCH];

    // Read multiplexer for control and status words.
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_CTL) begin
            rdata_o[NCH-1:0] = stop_q;
            rdata_o[OFF_BIT] = off_q;
        end else begin
            rdata_o[STS_RDY] = ready_i;
            rdata_o[STS_SEQ] = seq_q;
            rdata_o[STS_PWR] = !off_q;
        end
    end

    // History flag so $past is only read after a reset cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    // Reserved bits of the control word never read back as one.
    always_comb begin
        if (rst_n && (addr_i == ADDR_CTL)) begin
            assert_reserved_zero_R3: assert (rdata_o[OFF_BIT-1:NCH] == '0);
        end
    end

    assert_off_needs_acks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $rose(off_q)) |-> $past(&stop_ack_i));

    assert_seq_flag_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $rose(seq_q)) |-> $past(wr_en_i && (addr_i == ADDR_CTL)
                                              && wdata_i[OFF_BIT] && !off_q));
endmodule

// File: rtl/canram_pwr_seq.sv
// Module: top of the message RAM power sequencer.
// Wires the register file, the settle counter and the access guard together.
// Assumes one register access per clock and a synchronous active-low reset.
module canram_pwr_seq
    import canram_pkg::*;
#(
    parameter int unsigned NCH   = 8,
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NCH-1:0]    stop_ack_i,
    output logic [NCH-1:0]    stop_req_o,
    input  logic [CNT_W-1:0]  settle_dly_i,
    output logic              ram_pwr_en_o,
    output logic              ram_ready_o,
    input  logic              ram_acc_i,
    output logic              ram_addr_err_o
);
    logic ram_off;
    logic pwr_up;
    logic settling;
    logic ready;
    logic past_valid;

    canram_regs #(.NCH(NCH), .CNT_W(CNT_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (reg_wr_en),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .rdata_o    (reg_rdata),
        .stop_ack_i (stop_ack_i),
        .dly_i      (settle_dly_i),
        .settling_i (settling),
        .ready_i    (ready),
        .stop_req_o (stop_req_o),
        .ram_off_o  (ram_off),
        .pwr_up_o   (pwr_up)
    );

    canram_settle #(.CNT_W(CNT_W)) i_settle (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_up_i   (pwr_up),
        .ram_off_i  (ram_off),
        .dly_i      (settle_dly_i),
        .settling_o (settling),
        .ready_o    (ready)
    );

    canram_guard i_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_i   (ram_acc_i),
        .ready_i (ready),
        .err_o   (ram_addr_err_o)
    );

    assign ram_pwr_en_o = !ram_off;
    assign ram_ready_o  = ready;

    // History flag so $past is only read after a reset cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    assert_hold_during_settle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && settling && $past(settling))
            |-> (($past(stop_req_o) & ~stop_req_o) == '0));

    assert_off_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_pwr_en_o |-> !ram_ready_o);
endmodule

// File: tb/test_canram_pwr_seq.sv
// Bench: reference model checked against the block every cycle.
// Directed corners first, then a seeded random phase.
module test_canram_pwr_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic        addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [7:0]  ack;
    logic [7:0]  stop_o;
    logic [15:0] dly;
    logic        pwr_o;
    logic        rdy_o;
    logic        acc;
    logic        err_o;

    int checks   = 0;
    int failures = 0;

    // Reference state.
    logic [7:0] m_stop;
    logic [7:0] m_hold;
    logic       m_off;
    logic       m_seq;
    logic       m_err;
    int         m_cnt;

    always #4 clk = ~clk;

    canram_pwr_seq i_canram_pwr_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_wr_en      (wr_en),
        .reg_addr       (addr),
        .reg_wdata      (wdata),
        .reg_rdata      (rdata),
        .stop_ack_i     (ack),
        .stop_req_o     (stop_o),
        .settle_dly_i   (dly),
        .ram_pwr_en_o   (pwr_o),
        .ram_ready_o    (rdy_o),
        .ram_acc_i      (acc),
        .ram_addr_err_o (err_o)
    );

    function automatic logic m_ready();
        return !m_off && (m_cnt == 0);
    endfunction

    function automatic logic m_settling();
        return !m_off && (m_cnt != 0);
    endfunction

    function automatic logic [31:0] exp_rdata(input logic a);
        logic [31:0] v = '0;
        if (a == 1'b0) begin
            v[7:0] = m_stop;
            v[31]  = m_off;
        end else begin
            v[0] = m_ready();
            v[1] = m_seq;
            v[2] = !m_off;
        end
        return v;
    endfunction

    function automatic logic [7:0] exp_stop();
        return m_stop | (m_settling() ? m_hold : 8'h00);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Advance the reference model by one clock from the held inputs.
    task automatic model_edge();
        logic sett = m_settling();
        logic acc_ok = 1'b0;
        logic pu;
        m_err = acc && !m_ready();
        if (wr_en && addr == 1'b0) begin
            if (wdata[31] && !m_off && ack != 8'hFF) m_seq = 1'b1;
            else acc_ok = 1'b1;
        end
        if (wr_en && addr == 1'b1 && wdata[1]) m_seq = 1'b0;
        if (acc_ok) begin
            pu = m_off && !wdata[31];
            if (sett || (pu && dly != 16'd0)) m_hold = m_hold | (m_stop & ~wdata[7:0]);
            else m_hold = 8'h00;
            if (pu) m_cnt = int'(dly);
            else if (wdata[31]) m_cnt = 0;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            m_stop = wdata[7:0];
            m_off  = wdata[31];
        end else begin
            if (!sett) m_hold = 8'h00;
            if (m_off) m_cnt = 0;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
        end
    endtask

    // One clock: model at the rising edge, compare at the falling edge.
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R2", "stop_req", {24'd0, stop_o}, {24'd0, exp_stop()});
        chk("R4", "pwr_en", {31'd0, pwr_o}, {31'd0, !m_off});
        chk("R6", "ready", {31'd0, rdy_o}, {31'd0, m_ready()});
        chk("R8", "addr_err", {31'd0, err_o}, {31'd0, m_err});
        chk("R9", "rdata", rdata, exp_rdata(addr));
    endtask

    task automatic idle();
        wr_en = 1'b0;
        acc   = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; wr_en = 1'b0; addr = 1'b0; wdata = '0;
        ack = 8'hFF; dly = 16'd0; acc = 1'b0;
        m_stop = '0; m_hold = '0; m_off = 1'b0; m_seq = 1'b0; m_err = 1'b0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state on both words and every output.
        chk("R1", "ctl", rdata, 32'h0000_0000);
        addr = 1'b1;
        #1;
        chk("R1", "status", rdata, 32'h0000_0005);
        chk("R1", "stop_req", {24'd0, stop_o}, 32'd0);
        chk("R1", "pwr_en", {31'd0, pwr_o}, 32'd1);
        rst_n = 1'b1;
        step();

        // R2, R3: stop bits stored, reserved ones dropped.
        wr(1'b0, 32'h7FFF_FF5A);
        addr = 1'b0;
        #1;
        chk("R3", "reserved", rdata, 32'h0000_005A);
        chk("R2", "stop_out", {24'd0, stop_o}, 32'h0000_005A);

        // R5: power-down refused with an acknowledge missing.
        ack = 8'hFE;
        wr(1'b0, 32'h8000_00FF);
        chk("R5", "ctl_kept", rdata, 32'h0000_005A);
        addr = 1'b1;
        #1;
        chk("R5", "seq_flag", rdata & 32'h2, 32'h2);
        wr(1'b1, 32'h0000_0002);
        chk("R5", "seq_clear", rdata & 32'h2, 32'h0);

        // R4: power-down with all acknowledges.
        ack = 8'hFF;
        wr(1'b0, 32'h8000_00FF);
        chk("R4", "pwr_off", {31'd0, pwr_o}, 32'd0);
        // R8: access while off errors one clock later.
        acc = 1'b1; step(); acc = 1'b0;
        chk("R8", "err_off", {31'd0, err_o}, 32'd1);
        step();
        chk("R8", "err_one_cycle", {31'd0, err_o}, 32'd0);

        // R6, R7: wake with D=3 while clearing every request.
        dly = 16'd3;
        wr(1'b0, 32'h0000_0000);
        chk("R7", "held_at_wake", {24'd0, stop_o}, 32'h0000_00FF);
        chk("R6", "not_ready", {31'd0, rdy_o}, 32'd0);
        step(); step();
        chk("R7", "still_held", {24'd0, stop_o}, 32'h0000_00FF);
        step();
        chk("R6", "ready_after_3", {31'd0, rdy_o}, 32'd1);
        chk("R7", "released", {24'd0, stop_o}, 32'd0);

        // R6: wake with D=0 is ready on the first clock.
        wr(1'b0, 32'h8000_0000);
        dly = 16'd0;
        wr(1'b0, 32'h0000_0011);
        chk("R6", "ready_d0", {31'd0, rdy_o}, 32'd1);

        // Seeded random phase against the model.
        for (int i = 0; i < 3000; i++) begin
            wr_en = ($urandom_range(0, 2) == 0);
            addr  = ($urandom_range(0, 3) == 0);
            wdata = $urandom();
            if ($urandom_range(0, 1) == 0) wdata[31] = m_off ? 1'b0 : 1'b1;
            ack   = ($urandom_range(0, 3) == 0) ? 8'($urandom()) : 8'hFF;
            dly   = 16'($urandom_range(0, 12));
            acc   = $urandom_range(0, 1) == 1;
            step();
        end
        idle();
        step();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule